// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from a reference clock, called BRCLK here, using a 16-bit programmable divisor. It drives the bus clock line in open-drain fashion: it outputs only a pull-down enable. It also watches the wired clock line it shares with other devices. Because its timing follows the real line level, it joins clock synchronization with other masters. It also waits whenever a slave stretches the clock by holding the line low.

The divisor is clamped to a mode-dependent minimum: 4 in single-master mode and 8 in multi-master mode. The clamped value splits into a low half and a high half. The low half takes the spare cycle when the divisor is odd. The low half is timed from the moment the block starts pulling the line down. The high half is counted only over cycles in which the synchronized line reads high. The line sample passes through a two-stage synchronizer, and that adds two cycles to the observed high time.

Two one-cycle strobes tell a bit engine when the synchronized line has risen and when the block has begun a low phase.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, scl_drive_low, scl_rise_stb and scl_fall_stb are all 0.
- R2: With an even effective divisor D and an ideal bus (no other device pulling the line), the timing is as follows. scl_drive_low is held 1 for exactly D/2 cycles. It is then 0 for exactly D/2+2 cycles: two synchronizer cycles plus D/2 counted high cycles.
- R3: With an odd effective divisor D and an ideal bus, scl_drive_low is 1 for (D+1)/2 cycles and 0 for (D-1)/2+2 cycles.
- R4: In single-master mode (multi_master=0), any divisor below 4 behaves exactly like 4.
- R5: In multi-master mode (multi_master=1), any divisor below 8 behaves exactly like 8.
- R6: Suppose another device pulls the line low during the high phase, when the synchronized line has read high for fewer than the high-half cycles. Then scl_drive_low rises on the third clock edge after the line falls, and the low phase that follows lasts the full low half.
- R7: Suppose the line is held low externally after release, and the line rises within release cycle S-1, where S ≥ 1 counts cycles from release. Then scl_drive_low stays 0 for S+1+H cycles in total, where H is the high half. No high time is counted while the line is low.
- R8: scl_fall_stb is 1 for exactly one cycle: the first cycle of each run in which scl_drive_low is 1. It is 1 at no other time.
- R9: scl_rise_stb is 1 for one cycle per high phase. That cycle is the first one in which the synchronized line reads high, which is index G-H within a release run of G cycles (index 0 is the first run cycle).
- R10: After a clock edge that samples enable=0, scl_drive_low is 0 and both strobes are 0, whatever the line does.
- R11: After a clock edge that samples enable=1 while the block is idle, scl_drive_low is 1 and scl_fall_stb is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock BRCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Master clock generation enabled |
| multi_master | input | 1 | 1 selects multi-master minimum divisor 8, 0 selects single-master minimum 4 |
| divisor | input | DIV_W (16) | Unsigned BRCLK-to-SCL division factor |
| scl_in | input | 1 | Wired SCL line level, asynchronous |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise_stb | output | 1 | One-cycle pulse on synchronized SCL rising |
| scl_fall_stb | output | 1 | One-cycle pulse when a low phase begins |

## Verification
Even and odd divisors in both modes separate the two halving rules. Directed divisors from 0 to 9 show whether the clamp depends on the mode and falls at exactly 4 or 8. Random divisor and mode pairs widen the mix of lengths. An external pull during a long high phase checks that the block restarts its low phase early and keeps the full low length. An external hold after release checks that the wait lengthens by exactly the hold, and toggling the line while disabled shows that the block ignores it.

// File: rtl/scl_gen_pkg.sv
// Package: shared types of the SCL clock generator.
// Assumes nothing beyond IEEE 1800-2017.
package scl_gen_pkg;
    // Phase of the generated clock
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;
endpackage

// File: rtl/scl_in_sync.sv
// Module: scl_in_sync
// Brings the asynchronous wired SCL level into the BRCLK domain through a
// chain of STAGES flops. It also gives one more delayed copy for edge detection.
// Assumes the idle bus is high, so all stages reset to 1.
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_q
);
    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // first capture stage of the raw line
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_in;
                end
            end else begin : g_next
                // subsequent synchronizer / delay stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign line_s = chain[STAGES-1];
    assign line_q = chain[STAGES];
endmodule

// File: rtl/scl_period_calc.sv
// Module: scl_period_calc
// Clamps the programmed divisor to the minimum of the selected mode and
// splits it into a low half (ceiling) and a high half (floor).
// Assumes the divisor is stable while the generator runs.
module scl_period_calc #(
    parameter int DIV_W  = 16,
    parameter int SM_MIN = 4,
    parameter int MM_MIN = 8
) (
    input  logic [DIV_W-1:0] divisor,
    input  logic             multi_master,
    output logic [DIV_W-1:0] low_len,
    output logic [DIV_W-1:0] high_len
);
    localparam logic [DIV_W-1:0] SM_LIM = DIV_W'(SM_MIN);
    localparam logic [DIV_W-1:0] MM_LIM = DIV_W'(MM_MIN);

    logic [DIV_W-1:0] floor_v;
    logic [DIV_W-1:0] eff_div;

    // pick the mode minimum and clamp the divisor up to it
    always_comb begin
        floor_v = multi_master ? MM_LIM : SM_LIM;
        eff_div = (divisor < floor_v) ? floor_v : divisor;
    end

    // odd remainder goes to the low half
    always_comb begin
        high_len = eff_div >> 1;
        low_len  = eff_div - high_len;
    end
endmodule

// File: rtl/scl_phase_ctrl.sv
// Module: scl_phase_ctrl
// Phase sequencer: it times the low phase from its own pull-down and counts the
// high phase only over synchronized-high cycles. It restarts low as soon as
// the line is seen low during high, and idles with the line released when
// disabled.
// Assumes low_len and high_len are at least 2.
module scl_phase_ctrl
    import scl_gen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             line_s,
    input  logic             line_q,
    input  logic [DIV_W-1:0] low_len,
    input  logic [DIV_W-1:0] high_len,
    output logic             drive_low,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    scl_phase_e       phase;
    logic [DIV_W-1:0] cnt;

    // phase sequencing, phase counter and registered pull-down / fall strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            drive_low <= 1'b0;
            fall_stb  <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            if (!enable) begin
                phase     <= PH_IDLE;
                cnt       <= '0;
                drive_low <= 1'b0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        phase     <= PH_LOW;
                        cnt       <= ONE;
                        drive_low <= 1'b1;
                        fall_stb  <= 1'b1;
                    end
                    PH_LOW: begin
                        if (cnt >= low_len) begin
                            phase     <= PH_WAIT;
                            cnt       <= '0;
                            drive_low <= 1'b0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                    PH_WAIT: begin
                        if (line_s) begin
                            phase <= PH_HIGH;
                            cnt   <= ONE;
                        end
                    end
                    PH_HIGH: begin
                        if (!line_s || (cnt + ONE >= high_len)) begin
                            phase     <= PH_LOW;
                            cnt       <= ONE;
                            drive_low <= 1'b1;
                            fall_stb  <= 1'b1;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                    default: begin
                        phase     <= PH_IDLE;
                        cnt       <= '0;
                        drive_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    // rise strobe on the synchronized rising edge while active
    assign rise_stb = (phase != PH_IDLE) && line_s && !line_q;
endmodule

// File: rtl/scl_clock_gen.sv
// Module: scl_clock_gen (top)
// I2C master SCL generator: it divides BRCLK by a clamped 16-bit divisor and
// follows the wired SCL line for synchronization and stretching.
// Assumes scl_in already reflects the open-drain bus (pull-up plus all
// pull-downs, this block's included) and that divisor and multi_master
// change only while enable is 0.
module scl_clock_gen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SM_MIN      = 4,
    parameter int MM_MIN      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             multi_master,
    input  logic [DIV_W-1:0] divisor,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb
);
    logic             line_s;
    logic             line_q;
    logic [DIV_W-1:0] low_len;
    logic [DIV_W-1:0] high_len;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_in),
        .line_s  (line_s),
        .line_q  (line_q)
    );

    scl_period_calc #(.DIV_W(DIV_W), .SM_MIN(SM_MIN), .MM_MIN(MM_MIN)) u_calc (
        .divisor      (divisor),
        .multi_master (multi_master),
        .low_len      (low_len),
        .high_len     (high_len)
    );

    scl_phase_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .line_s    (line_s),
        .line_q    (line_q),
        .low_len   (low_len),
        .high_len  (high_len),
        .drive_low (scl_drive_low),
        .rise_stb  (scl_rise_stb),
        .fall_stb  (scl_fall_stb)
    );
endmodule

// File: rtl/scl_clock_gen_chk.sv
// Module: scl_clock_gen_chk
// Port-level checker bound to scl_clock_gen. It tracks the length of each
// pull-down run with its own counter.
// Assumes divisor and mode are stable while enabled.
module scl_clock_gen_chk #(
    parameter int DIV_W  = 16,
    parameter int SM_MIN = 4,
    parameter int MM_MIN = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             multi_master,
    input logic [DIV_W-1:0] divisor,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             scl_rise_stb,
    input logic             scl_fall_stb
);
    logic [DIV_W:0] run_len;
    logic [DIV_W:0] want_low;
    logic [DIV_W:0] dmin;
    logic [DIV_W:0] deff;

    // expected low length from the requirement
    always_comb begin
        dmin     = multi_master ? (DIV_W+1)'(MM_MIN) : (DIV_W+1)'(SM_MIN);
        deff     = ({1'b0, divisor} < dmin) ? dmin : {1'b0, divisor};
        want_low = deff - (deff >> 1);
    end

    // counts completed cycles of the current pull-down run
    always_ff @(posedge clk) begin
        if (!rst_n)             run_len <= '0;
        else if (scl_drive_low) run_len <= run_len + 1'b1;
        else                    run_len <= '0;
    end

    // R8
    fall_marks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !scl_rise_stb && !scl_fall_stb));

    // R9
    rise_follows_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_stb |-> ($past(scl_in, 2) && !$past(scl_in, 3)));

    // R2
    low_ends_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && enable && (run_len == want_low - 1'b1)) |=> !scl_drive_low);

    // R3
    low_not_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && enable && (run_len < want_low - 1'b1)) |=> scl_drive_low);

    // R11
    enable_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !scl_drive_low && !$past(enable)) |=> (scl_drive_low && scl_fall_stb));
endmodule

bind scl_clock_gen scl_clock_gen_chk #(.DIV_W(DIV_W), .SM_MIN(SM_MIN), .MM_MIN(MM_MIN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .multi_master  (multi_master),
    .divisor       (divisor),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .scl_rise_stb  (scl_rise_stb),
    .scl_fall_stb  (scl_fall_stb)
);

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        multi_master = 1'b0;
    logic [15:0] divisor = 16'd10;
    logic        ext_low = 1'b0;
    logic        scl_in;
    logic        scl_drive_low;
    logic        scl_rise_stb;
    logic        scl_fall_stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fall_bad = 0;
    int rise_bad = 0;
    logic prev_drive = 1'b0;
    bit   done = 1'b0;

    assign scl_in = !scl_drive_low && !ext_low;

    scl_clock_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .multi_master(multi_master),
        .divisor(divisor), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb)
    );

    always #5 clk = ~clk;

    function automatic int eff_div(int d, bit mm);
        int m = mm ? 8 : 4;
        return (d < m) ? m : d;
    endfunction
    function automatic int exp_low(int d, bit mm);
        int e = eff_div(d, mm);
        return e - e / 2;
    endfunction
    function automatic int exp_high(int d, bit mm);
        return eff_div(d, mm) / 2;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // strobe monitor at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && enable) begin
            if (scl_fall_stb != (scl_drive_low && !prev_drive)) fall_bad++;
            if (scl_rise_stb && scl_drive_low) rise_bad++;
        end
        prev_drive = scl_drive_low;
    end

    // watchdog
    initial begin
        while (cyc < 150000 && !done) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic restart(input int d, input bit mm);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        divisor = 16'(d);
        multi_master = mm;
        enable = 1'b1;
        @(negedge clk);
    endtask

    // one full release run then one low run, ideal bus
    task automatic measure(input int d, input bit mm, input string tag);
        int g = 0; int l = 0; int rc = 0; int ri = -1;
        restart(d, mm);
        while (scl_drive_low) @(negedge clk);
        while (!scl_drive_low) begin
            if (scl_rise_stb) begin rc++; ri = g; end
            g++;
            @(negedge clk);
        end
        while (scl_drive_low) begin l++; @(negedge clk); end
        check(l == exp_low(d, mm), {tag, " low"}, l, exp_low(d, mm));
        check(g == exp_high(d, mm) + 2, {tag, " release"}, g, exp_high(d, mm) + 2);
        check(rc == 1 && ri == g - exp_high(d, mm), "R9 rise position", ri, g - exp_high(d, mm));
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!scl_drive_low, "R1 drive in reset", scl_drive_low, 0);
        check(!scl_rise_stb && !scl_fall_stb, "R1 strobes in reset", scl_fall_stb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low && !scl_fall_stb && !scl_rise_stb, "R1 after reset", scl_drive_low, 0);

        // R11 start
        divisor = 16'd10;
        enable = 1'b1;
        @(negedge clk);
        check(scl_drive_low && scl_fall_stb, "R11 start low", scl_drive_low, 1);

        // R2 even / R3 odd directed
        measure(4, 0, "R2 d4");
        measure(6, 0, "R2 d6");
        measure(5, 0, "R3 d5");
        measure(7, 0, "R3 d7");
        measure(9, 1, "R3 d9 mm");
        measure(16, 1, "R2 d16 mm");
        // R4 single-master clamp
        for (int d = 0; d < 4; d++) measure(d, 0, "R4 clamp");
        // R5 multi-master clamp
        measure(0, 1, "R5 clamp");
        measure(5, 1, "R5 clamp");
        measure(7, 1, "R5 clamp");
        measure(8, 1, "R5 d8");

        // random mix
        for (int i = 0; i < 24; i++) begin
            int  d  = int'($urandom % 48);
            bit  mm = bit'($urandom % 2);
            measure(d, mm, (eff_div(d, mm) % 2 == 0) ? "R2 random" : "R3 random");
        end

        // R7 stretching by external hold after release
        begin
            int g = 0; int s = 7;
            restart(10, 0);
            ext_low = 1'b1;
            while (scl_drive_low) @(negedge clk);
            while (!scl_drive_low) begin
                if (g == s - 1) ext_low = 1'b0;
                g++;
                @(negedge clk);
            end
            check(g == s + 1 + exp_high(10, 0), "R7 stretch release", g, s + 1 + exp_high(10, 0));
        end

        // R6 early low from another device
        begin
            int l = 0;
            restart(40, 0);
            while (scl_drive_low) @(negedge clk);
            while (!scl_rise_stb) @(negedge clk);
            repeat (3) @(negedge clk);
            ext_low = 1'b1;
            repeat (2) @(negedge clk);
            check(!scl_drive_low, "R6 not yet low", scl_drive_low, 0);
            @(negedge clk);
            check(scl_drive_low && scl_fall_stb, "R6 early low start", scl_drive_low, 1);
            ext_low = 1'b0;
            while (scl_drive_low) begin l++; @(negedge clk); end
            check(l == exp_low(40, 0), "R6 full low after sync", l, exp_low(40, 0));
        end

        // R10 disable releases and ignores bus
        begin
            int bad = 0;
            restart(20, 1);
            repeat (3) @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            check(!scl_drive_low, "R10 released", scl_drive_low, 0);
            for (int i = 0; i < 20; i++) begin
                ext_low = (i % 3) == 0;
                @(negedge clk);
                if (scl_drive_low || scl_rise_stb || scl_fall_stb) bad++;
            end
            ext_low = 1'b0;
            check(bad == 0, "R10 quiet while disabled", bad, 0);
        end

        check(fall_bad == 0, "R8 fall strobe placement", fall_bad, 0);
        check(rise_bad == 0, "R9 rise strobe while low", rise_bad, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule